// File: doc/BRIEF.md
# Output Stage Power-On Switch Sequencer

This controller decides, clock by clock, which of the six transmission gates in one converter channel's output stage are closed. Two gates choose the amplifier's input: the converter code path or the ground-sense pin. The other four set the amplifier arrangement. One arrangement is a unity buffer whose output is also pulled toward ground-sense through a resistor. The other is the gain-of-two arrangement used in normal operation.

The block reacts to two digital levels. The first is a supply-good flag, raised once the analog rails are high enough. The second is an already-synchronized active-low clear. The gain arrangement is entered only after supply-good has stayed high for a programmable number of clock edges, and it is left in the same cycle that supply-good falls. The input-select pair follows the clear level at all times. Whenever that pair changes over, both gates are open for one clock before the new one closes.

Gate enables are numbered G1..G6 on `gate_en[0]`..`gate_en[5]`, and a 1 means closed. G1 connects the converter to the amplifier input and G2 connects ground-sense to it. G3 and G5 form the unpowered buffer and pull-down arrangement, and G4 and G6 form the gain arrangement.

Top module: `outstage_gate_seq`

## Requirements
- R1: One clock edge after `rst_n` is sampled low, with `supply_ok` low, `gate_en` is 6'b010110: G2, G3 and G5 closed, all others open. `seq_state` is 0.
- R2: While the block is not in the gain arrangement, G3 and G5 are closed and G4 and G6 are open. This holds both with `supply_ok` low and during settling.
- R3: Once `supply_ok` has been sampled high at `settle_len` consecutive rising edges, G4 and G6 close and G3 and G5 open after that edge. A `settle_len` of 0 behaves as 1.
- R4: Whenever `supply_ok` is low, G4 and G6 are open and G3 and G5 are closed in that same cycle, with no clock edge needed.
- R5: When `clr_n` has been low for two edges, G2 is closed and G1 is open, whatever the supply condition.
- R6: When `clr_n` has been high for two edges, G1 is closed and G2 is open, whatever the supply condition.
- R7: G1 and G2 are never closed together. After a change of `clr_n`, the closed gate of the pair opens at the first edge and the other closes at the following edge.
- R8: `seq_state` reads 0 while `supply_ok` is low, 1 while `supply_ok` is high but settling is not complete, and 2 in the gain arrangement.
- R9: A low on `supply_ok` during settling restarts the count. After `supply_ok` rises again, a full `settle_len` edges are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Analog supplies above threshold |
| clr_n | input | 1 | Synchronized active-low clear level |
| settle_len | input | CNT_W | Edges `supply_ok` must stay high before gain mode |
| gate_en | output | 6 | Gate enables, bit i is G(i+1), 1 = closed |
| seq_state | output | 2 | 0 unpowered, 1 settling, 2 gain arrangement |

## Verification
The hardest situation to reach from the ports is a settling period that is cut short by a supply dip. The count must then restart from zero rather than resume. To reach it, the bench raises `supply_ok` for fewer edges than `settle_len`, drops it for one cycle, and raises it again. It then checks that the gain arrangement appears only after a full new count. A second awkward case is a `clr_n` reversal in the middle of the break-before-make gap. The bench toggles the clear on consecutive cycles and checks that the pair of gates is never closed together.

// File: rtl/outstage_pkg.sv
// Shared types and gate indices for the output-stage sequencer.
// Assumes gate enables are active high (1 = gate closed).
package outstage_pkg;
    localparam int NUM_GATES = 6;
    localparam int G1_IDX = 0;
    localparam int G2_IDX = 1;
    localparam int G3_IDX = 2;
    localparam int G4_IDX = 3;
    localparam int G5_IDX = 4;
    localparam int G6_IDX = 5;

    typedef enum logic [1:0] {
        SEQ_OFF    = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_GAIN   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ostg_settle_timer.sv
// Settle qualifier: raises pwr_good once supply_ok has been high for
// settle_len consecutive edges (0 treated as 1). Any low sample restarts.
// Assumes supply_ok is already synchronous to clk.
module ostg_settle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic [CNT_W-1:0] settle_len,
    output logic             pwr_good
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] target;
    logic [EXT_W-1:0] cnt_next;

    // Effective target count, minimum one edge.
    always_comb begin
        target   = (settle_len == '0) ? EXT_W'(1) : {1'b0, settle_len};
        cnt_next = {1'b0, cnt_q} + EXT_W'(1);
    end

    // Count qualifying edges; clear on reset or any supply low sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            cnt_q    <= '0;
            pwr_good <= 1'b0;
        end else if (!pwr_good) begin
            cnt_q <= cnt_next[CNT_W-1:0];
            if (cnt_next >= target) begin
                pwr_good <= 1'b1;
            end
        end
    end

    // R3: good only ever rises after a high supply sample.
    a_r3_rise_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_good) |-> $past(supply_ok));

    // R9: a low supply sample always removes good at the next edge.
    a_r9_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !pwr_good);
endmodule

// File: rtl/ostg_mux_bbm.sv
// Amplifier input selector for G1 (converter) and G2 (ground-sense) with
// one clock of break-before-make. Reset selects ground-sense.
// Assumes clr_n is synchronized; clr_n high requests the converter path.
module ostg_mux_bbm (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    output logic g1_q,
    output logic g2_q
);
    logic want_dac;

    // Requested input source.
    always_comb want_dac = clr_n;

    // Open the closed gate first, close the requested one only once both are open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g1_q <= 1'b0;
            g2_q <= 1'b1;
        end else begin
            g1_q <= want_dac && !g2_q;
            g2_q <= !want_dac && !g1_q;
        end
    end

    // R7: the two input gates are never closed together.
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(g1_q && g2_q));

    // R7: G1 closes only after a cycle with G2 open.
    a_r7_gap_g1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g1_q) |-> !$past(g2_q));

    // R6: steady clear high selects the converter.
    a_r6_dac_selected: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(clr_n) && $past(clr_n, 2)) |-> g1_q);

    // R5: steady clear low selects ground-sense.
    a_r5_gnd_selected: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(clr_n) && !$past(clr_n, 2)) |-> g2_q);
endmodule

// File: rtl/ostg_amp_cfg.sv
// Amplifier arrangement gates G3..G6: unity buffer with pull to
// ground-sense when not in gain mode, gain-of-two otherwise.
// Assumes gain_mode already includes the live supply level.
module ostg_amp_cfg (
    input  logic gain_mode,
    output logic g3,
    output logic g4,
    output logic g5,
    output logic g6
);
    // Buffer gates follow the unpowered arrangement, gain gates the powered one.
    always_comb begin
        g3 = !gain_mode;
        g5 = !gain_mode;
        g4 = gain_mode;
        g6 = gain_mode;
    end
endmodule

// File: rtl/outstage_gate_seq.sv
// Top of the output-stage power-on sequencer for one channel.
// Combines supply settling, clear-driven input selection and amplifier
// arrangement into six gate enables and a state indication.
// Assumes supply_ok and clr_n are synchronous to clk.
module outstage_gate_seq #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             clr_n,
    input  logic [CNT_W-1:0] settle_len,
    output logic [5:0]       gate_en,
    output logic [1:0]       seq_state
);
    import outstage_pkg::*;

    logic pwr_good;
    logic gain_mode;
    logic g1, g2, g3, g4, g5, g6;
    seq_state_e st;

    ostg_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok  (supply_ok),
        .settle_len (settle_len),
        .pwr_good   (pwr_good)
    );

    ostg_mux_bbm u_mux (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .g1_q  (g1),
        .g2_q  (g2)
    );

    // Gain mode needs both a settled timer and a live supply (instant drop).
    always_comb gain_mode = pwr_good && supply_ok;

    ostg_amp_cfg u_amp (
        .gain_mode (gain_mode),
        .g3        (g3),
        .g4        (g4),
        .g5        (g5),
        .g6        (g6)
    );

    // Pack gate enables by index.
    always_comb begin
        gate_en         = '0;
        gate_en[G1_IDX] = g1;
        gate_en[G2_IDX] = g2;
        gate_en[G3_IDX] = g3;
        gate_en[G4_IDX] = g4;
        gate_en[G5_IDX] = g5;
        gate_en[G6_IDX] = g6;
    end

    // State indication from supply level and settle status.
    always_comb begin
        if (!supply_ok)     st = SEQ_OFF;
        else if (!pwr_good) st = SEQ_SETTLE;
        else                st = SEQ_GAIN;
        seq_state = st;
    end

    // R4: low supply always shows the unpowered amplifier arrangement.
    a_r4_drop_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> (!gate_en[G4_IDX] && !gate_en[G6_IDX] && gate_en[G3_IDX] && gate_en[G5_IDX]));

    // R2: outside gain state the buffer gates are closed.
    a_r2_buffer_when_not_gain: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != 2'd2) |-> (gate_en[G3_IDX] && gate_en[G5_IDX]));

    // R8: gain state is entered only from settling.
    a_r8_gain_from_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd2 && $past(seq_state) != 2'd2) |-> ($past(seq_state) == 2'd1));
endmodule

// File: tb/sim_outstage_gate_seq.sv
module sim_outstage_gate_seq;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             supply_ok = 1'b0;
    logic             clr_n = 1'b0;
    logic [CNT_W-1:0] settle_len = '0;
    logic [5:0]       gate_en;
    logic [1:0]       seq_state;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Expected patterns, bits G6..G1
    localparam logic [5:0] P_OFF_GND  = 6'b010110;
    localparam logic [5:0] P_OFF_DAC  = 6'b010101;
    localparam logic [5:0] P_OFF_NONE = 6'b010100;
    localparam logic [5:0] P_GAIN_GND = 6'b101010;
    localparam logic [5:0] P_GAIN_DAC = 6'b101001;
    localparam logic [5:0] P_GAIN_NONE = 6'b101000;

    always #4 clk = ~clk;

    outstage_gate_seq #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .clr_n(clr_n),
        .settle_len(settle_len), .gate_en(gate_en), .seq_state(seq_state)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; supply_ok = 1'b0; clr_n = 1'b0; settle_len = 16'd5;
        step(3);
        chk("R1 gates", {2'b0, gate_en}, {2'b0, P_OFF_GND});
        chk("R1 state", {6'b0, seq_state}, 8'd0);
        rst_n = 1'b1;
        step(2);
        chk("R2 unpowered hold", {2'b0, gate_en}, {2'b0, P_OFF_GND});
    endtask

    task automatic t_clear_unpowered();
        clr_n = 1'b1;
        step(1);
        chk("R7 gap unpowered", {2'b0, gate_en}, {2'b0, P_OFF_NONE});
        step(1);
        chk("R6 dac unpowered", {2'b0, gate_en}, {2'b0, P_OFF_DAC});
        clr_n = 1'b0;
        step(1);
        chk("R7 gap back", {2'b0, gate_en}, {2'b0, P_OFF_NONE});
        step(1);
        chk("R5 gnd unpowered", {2'b0, gate_en}, {2'b0, P_OFF_GND});
    endtask

    task automatic t_settle_gnd();
        settle_len = 16'd5;
        supply_ok = 1'b1;
        step(4);
        chk("R2 settling gates", {2'b0, gate_en}, {2'b0, P_OFF_GND});
        chk("R8 settling state", {6'b0, seq_state}, 8'd1);
        step(1);
        chk("R3 gain gnd", {2'b0, gate_en}, {2'b0, P_GAIN_GND});
        chk("R8 gain state", {6'b0, seq_state}, 8'd2);
    endtask

    task automatic t_clear_release_powered();
        clr_n = 1'b1;
        step(1);
        chk("R7 gap powered", {2'b0, gate_en}, {2'b0, P_GAIN_NONE});
        step(1);
        chk("R6 dac powered", {2'b0, gate_en}, {2'b0, P_GAIN_DAC});
    endtask

    task automatic t_drop();
        supply_ok = 1'b0;
        #1;
        chk("R4 instant drop", {2'b0, gate_en}, {2'b0, P_OFF_DAC});
        chk("R8 off state", {6'b0, seq_state}, 8'd0);
        step(2);
        chk("R4 stays unpowered", {2'b0, gate_en}, {2'b0, P_OFF_DAC});
    endtask

    task automatic t_restart();
        settle_len = 16'd6;
        supply_ok = 1'b1;
        step(4);
        supply_ok = 1'b0;
        step(1);
        supply_ok = 1'b1;
        step(5);
        chk("R9 restarted count", {6'b0, seq_state}, 8'd1);
        chk("R9 no early gain", {2'b0, gate_en}, {2'b0, P_OFF_DAC});
        step(1);
        chk("R9 gain after full", {2'b0, gate_en}, {2'b0, P_GAIN_DAC});
    endtask

    task automatic t_toggle();
        bit overlap = 1'b0;
        for (int i = 0; i < 6; i++) begin
            clr_n = ~clr_n;
            step(1);
            if (gate_en[0] && gate_en[1]) overlap = 1'b1;
        end
        chk("R7 no overlap toggling", {7'b0, overlap}, 8'd0);
        clr_n = 1'b0;
        step(3);
        chk("R5 gnd powered", {2'b0, gate_en}, {2'b0, P_GAIN_GND});
    endtask

    task automatic t_zero_len();
        supply_ok = 1'b0;
        step(1);
        settle_len = 16'd0;
        supply_ok = 1'b1;
        #1;
        chk("R8 settle at zero len", {6'b0, seq_state}, 8'd1);
        step(1);
        chk("R3 zero len as one", {2'b0, gate_en}, {2'b0, P_GAIN_GND});
    endtask

    initial begin
        t_reset();
        t_clear_unpowered();
        t_settle_gnd();
        t_clear_release_powered();
        t_drop();
        t_restart();
        t_toggle();
        t_zero_len();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule